// File: doc/BRIEF.md
# Accumulator ALU with Carry/Borrow Flag

This block holds an 8-bit working accumulator and a one-bit carry flag and updates both from a memory operand byte under an operation code. It covers addition with and without incoming carry, subtraction in both directions with and without incoming borrow, bitwise AND, OR and XOR, and logical and through-flag shifts in both directions. A load operation copies the operand straight into the accumulator. A zero indication derived from the accumulator feeds branch and skip decisions elsewhere in the datapath.

The flag has two meanings. After an addition it is the carry out. After a subtraction it is set when no borrow occurred, so a clear flag marks a two's-complement result. Only arithmetic and shift operations write the flag. Loads and logic operations leave it as it was. One enable input gates every update, so the sequencer can hold the accumulator across cycles that do not touch it.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc_q` becomes 0x00 and `flag_q` becomes 0. `acc_zero` is then 1.
- R2: While `upd_en` is 0, `acc_q` and `flag_q` keep their values whatever `op` and `opnd` are.
- R3: Op code 1 (load) copies `opnd` into `acc_q` and leaves `flag_q` unchanged.
- R4: Op code 2 (add) writes (opnd + acc) mod 256 to `acc_q` and the carry out to `flag_q`, ignoring the old flag. Op code 3 (add with carry) also adds the old flag.
- R5: Op code 4 writes opnd − acc and op code 5 writes opnd − acc − (1 − flag). Both compute mod 256 and set `flag_q` to 1 exactly when no borrow occurred. Op code 4 treats the incoming flag as "no borrow".
- R6: Op code 6 writes acc − opnd and op code 7 writes acc − opnd − (1 − flag). Both compute mod 256 and use the same no-borrow flag rule as R5.
- R7: Op codes 8, 9 and 10 write acc AND opnd, acc OR opnd and acc XOR opnd, and leave `flag_q` unchanged.
- R8: Op code 11 shifts right: bit 0 goes to `flag_q` and bit 7 fills with 0. Op code 13 shifts left: bit 7 goes to `flag_q` and bit 0 fills with 0.
- R9: Op code 12 rotates right through the flag: bit 0 goes to `flag_q` and the old flag goes to bit 7. Op code 14 rotates left through the flag: bit 7 goes to `flag_q` and the old flag goes to bit 0.
- R10: `acc_zero` is 1 exactly when `acc_q` is 0x00, in the same cycle.
- R11: Op codes 0 and 15 change neither `acc_q` nor `flag_q`, even with `upd_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update enable for accumulator and flag |
| op | input | 4 | Operation code (see requirements) |
| opnd | input | 8 | Memory operand byte |
| acc_q | output | 8 | Registered accumulator |
| flag_q | output | 1 | Registered carry / no-borrow flag |
| acc_zero | output | 1 | High when the accumulator is zero |

## Verification
A wrong carry-in selection or a wrong operand inversion in the adder shows up in `acc_q` or `flag_q` one edge after the operation. It shows most clearly at 0x00 and 0xFF, where a single lost unit flips the flag. A flag write enable that is too wide shows up as a changed `flag_q` one edge after a load or logic operation. A swapped rotate fill shows up in the top or bottom bit on that same edge. The bench presets the accumulator and the flag and then applies each operation across a grid of values that includes both boundaries. This exposes every such fault within a single cycle of the operation that triggers it.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_NOP0  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_ADD   = 4'd2,
    OP_ADC   = 4'd3,
    OP_SUBD  = 4'd4,
    OP_SUBDB = 4'd5,
    OP_SUBM  = 4'd6,
    OP_SUBMB = 4'd7,
    OP_AND   = 4'd8,
    OP_OR    = 4'd9,
    OP_XOR   = 4'd10,
    OP_SHR   = 4'd11,
    OP_RSHR  = 4'd12,
    OP_SHL   = 4'd13,
    OP_RSHL  = 4'd14,
    OP_NOP1  = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_NONE  = 2'd0,
    GRP_ARITH = 2'd1,
    GRP_LOGIC = 2'd2,
    GRP_SHIFT = 2'd3
  } alu_grp_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   opnd,
  input  logic           flag,
  output logic [W-1:0]   res,
  output logic           cout
);
  logic [W-1:0] lhs, rhs;
  logic         cin;
  logic [W:0]   sum;

  // Subtraction as lhs + ~rhs + cin; carry out is the no-borrow flag.
  always_comb begin
    lhs = opnd;
    rhs = acc;
    cin = 1'b0;
    unique case (op)
      OP_ADD:   begin lhs = opnd; rhs = acc;  cin = 1'b0; end
      OP_ADC:   begin lhs = opnd; rhs = acc;  cin = flag; end
      OP_SUBD:  begin lhs = opnd; rhs = ~acc; cin = 1'b1; end
      OP_SUBDB: begin lhs = opnd; rhs = ~acc; cin = flag; end
      OP_SUBM:  begin lhs = acc;  rhs = ~opnd; cin = 1'b1; end
      OP_SUBMB: begin lhs = acc;  rhs = ~opnd; cin = flag; end
      default:  begin lhs = opnd; rhs = acc;  cin = 1'b0; end
    endcase
  end

  assign sum  = {1'b0, lhs} + {1'b0, rhs} + {{W{1'b0}}, cin};
  assign res  = sum[W-1:0];
  assign cout = sum[W];
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   opnd,
  output logic [W-1:0]   res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = acc & opnd;
      OP_OR:   res = acc | opnd;
      OP_XOR:  res = acc ^ opnd;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   acc,
  input  logic           flag,
  output logic [W-1:0]   res,
  output logic           fout
);
  logic right;
  logic fill;

  always_comb begin
    right = (op == OP_SHR) || (op == OP_RSHR);
    fill  = ((op == OP_RSHR) || (op == OP_RSHL)) ? flag : 1'b0;
  end

  always_comb begin
    if (right) begin
      res  = {fill, acc[W-1:1]};
      fout = acc[0];
    end else begin
      res  = {acc[W-2:0], fill};
      fout = acc[W-1];
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd_en,
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd,
  output logic [W-1:0] acc_q,
  output logic         flag_q,
  output logic         acc_zero
);
  alu_op_e      op_e;
  alu_grp_e     grp;
  logic [W-1:0] ar_res, lg_res, sh_res;
  logic         ar_c, sh_c;
  logic [W-1:0] acc_d;
  logic         flag_d;
  logic         acc_we, flag_we;

  assign op_e = alu_op_e'(op);

  always_comb begin
    unique case (op_e)
      OP_ADD, OP_ADC, OP_SUBD, OP_SUBDB, OP_SUBM, OP_SUBMB: grp = GRP_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_LOAD:                       grp = GRP_LOGIC;
      OP_SHR, OP_RSHR, OP_SHL, OP_RSHL:                     grp = GRP_SHIFT;
      default:                                              grp = GRP_NONE;
    endcase
  end

  acc_alu_arith #(.W(W)) u_arith (
    .op(op_e), .acc(acc_q), .opnd(opnd), .flag(flag_q),
    .res(ar_res), .cout(ar_c)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op(op_e), .acc(acc_q), .opnd(opnd), .res(lg_res)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .op(op_e), .acc(acc_q), .flag(flag_q), .res(sh_res), .fout(sh_c)
  );

  always_comb begin
    acc_d   = acc_q;
    flag_d  = flag_q;
    acc_we  = 1'b0;
    flag_we = 1'b0;
    unique case (grp)
      GRP_ARITH: begin acc_d = ar_res; flag_d = ar_c; acc_we = 1'b1; flag_we = 1'b1; end
      GRP_SHIFT: begin acc_d = sh_res; flag_d = sh_c; acc_we = 1'b1; flag_we = 1'b1; end
      GRP_LOGIC: begin acc_d = lg_res; acc_we = 1'b1; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd_en) begin
      if (acc_we)  acc_q  <= acc_d;
      if (flag_we) flag_q <= flag_d;
    end
  end

  assign acc_zero = (acc_q == '0);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         upd_en,
  input logic [3:0]   op,
  input logic [W-1:0] opnd,
  input logic [W-1:0] acc_q,
  input logic         flag_q,
  input logic         acc_zero
);
  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !flag_q);

  // R2
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(acc_q) && $stable(flag_q));

  // R3
  a_r3_load_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == 4'd1) |=> (acc_q == $past(opnd)) && $stable(flag_q));

  // R7
  a_r7_logic_keeps_flag: assert property (@(posedge clk) disable iff (rst)
    (upd_en && (op == 4'd8 || op == 4'd9 || op == 4'd10)) |=> $stable(flag_q));

  // R8
  a_r8_shift_right_fill: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == 4'd11) |=> !acc_q[W-1] && (flag_q == $past(acc_q[0])));

  a_r8_shift_left_fill: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == 4'd13) |=> !acc_q[0] && (flag_q == $past(acc_q[W-1])));

  // R9
  a_r9_rotate_right: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == 4'd12) |=> (acc_q[W-1] == $past(flag_q)) && (flag_q == $past(acc_q[0])));

  a_r9_rotate_left: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == 4'd14) |=> (acc_q[0] == $past(flag_q)) && (flag_q == $past(acc_q[W-1])));

  // R10
  a_r10_zero_after_zero_load: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == 4'd1 && opnd == '0) |=> acc_zero);

  // R11
  a_r11_nop_no_effect: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 || op == 4'd15) |=> $stable(acc_q) && $stable(flag_q));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .upd_en(upd_en), .op(op), .opnd(opnd),
  .acc_q(acc_q), .flag_q(flag_q), .acc_zero(acc_zero)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       upd_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opnd = 8'd0;
  logic [7:0] acc_q;
  logic       flag_q;
  logic       acc_zero;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  acc_alu #(.W(8)) uut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op(op), .opnd(opnd),
    .acc_q(acc_q), .flag_q(flag_q), .acc_zero(acc_zero)
  );

  function automatic string req_of(input int o);
    case (o)
      1: return "R3";
      2, 3: return "R4";
      4, 5: return "R5";
      6, 7: return "R6";
      8, 9, 10: return "R7";
      11, 13: return "R8";
      12, 14: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Reference: returns {flag, acc}
  function automatic logic [8:0] model(input int o, input int a, input int f, input int m);
    int s;
    int rf;
    rf = f;
    case (o)
      1:  s = m;
      2:  begin s = m + a;     rf = (s > 255); end
      3:  begin s = m + a + f; rf = (s > 255); end
      4:  begin s = m - a;           rf = (s >= 0); end
      5:  begin s = m - a - (1 - f); rf = (s >= 0); end
      6:  begin s = a - m;           rf = (s >= 0); end
      7:  begin s = a - m - (1 - f); rf = (s >= 0); end
      8:  s = a & m;
      9:  s = a | m;
      10: s = a ^ m;
      11: begin rf = a % 2; s = a / 2; end
      12: begin rf = a % 2; s = a / 2 + 128 * f; end
      13: begin rf = a / 128; s = (a * 2) % 256; end
      14: begin rf = a / 128; s = (a * 2) % 256 + f; end
      default: s = a;
    endcase
    s = ((s % 256) + 256) % 256;
    return {rf[0], s[7:0]};
  endfunction

  task automatic apply(input logic en, input logic [3:0] o, input logic [7:0] m);
    upd_en = en; op = o; opnd = m;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] ea, input logic ef);
    checks++;
    if (acc_q !== ea || flag_q !== ef || acc_zero !== (ea == 8'h00)) begin
      fails++;
      $display("FAIL %s: acc=%02h flag=%0b zero=%0b expected acc=%02h flag=%0b zero=%0b",
               req, acc_q, flag_q, acc_zero, ea, ef, (ea == 8'h00));
    end
  endtask

  // Preset accumulator and flag through the normal interface.
  task automatic preset(input logic [7:0] a, input logic f);
    apply(1'b1, 4'd1, f ? 8'h80 : 8'h00);
    apply(1'b1, 4'd13, 8'h00);
    apply(1'b1, 4'd1, a);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] e;
    @(negedge clk);
    apply(1'b1, 4'd1, 8'hA5);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1", 8'h00, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    // R10 zero flag after a zero and a nonzero load
    preset(8'h00, 1'b1);
    check("R10", 8'h00, 1'b1);
    preset(8'h01, 1'b0);
    check("R10", 8'h01, 1'b0);

    // Main sweep over every op code, accumulator, flag and operand grid.
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 16; i++) begin
        for (int f = 0; f < 2; f++) begin
          for (int j = 0; j < 16; j++) begin
            logic [7:0] a;
            logic [7:0] m;
            a = 8'(i * 17);
            m = 8'((j * 17) ^ ((j == 5) ? 1 : 0));
            preset(a, f[0]);
            apply(1'b1, 4'(o), m);
            e = model(o, a, f, m);
            check(req_of(o), e[7:0], e[8]);
          end
        end
      end
    end

    // R2 enable low: no op code has any effect
    for (int o = 0; o < 16; o++) begin
      preset(8'h3C, o[0]);
      apply(1'b0, 4'(o), 8'hFF);
      check("R2", 8'h3C, o[0]);
    end

    // R4 R5 R6 boundary cases
    preset(8'hFF, 1'b1); apply(1'b1, 4'd3, 8'h00); check("R4", 8'h00, 1'b1);
    preset(8'hFF, 1'b1); apply(1'b1, 4'd2, 8'h00); check("R4", 8'hFF, 1'b0);
    preset(8'h00, 1'b0); apply(1'b1, 4'd5, 8'h00); check("R5", 8'hFF, 1'b0);
    preset(8'h00, 1'b0); apply(1'b1, 4'd4, 8'h00); check("R5", 8'h00, 1'b1);
    preset(8'h00, 1'b1); apply(1'b1, 4'd6, 8'h01); check("R6", 8'hFF, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule